// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is the processor-control timer that keeps a 32-bit up-counter and a 32-bit comparison value. The counter advances once per tick, which defaults to one tick per clock at 100 MHz. When the counter value equals the comparison value while counting is enabled, a sticky timer interrupt is raised. The interrupt is placed on one of eight request lines, picked by a 3-bit routing field. Software writes either register through a single write port with a select bit, and can read both registers at any time.

A level input freezes the counter. While it is high, the counter holds its value, writes load the held value directly, and no match is detected. The only way to acknowledge the interrupt is to write the comparison register. A cause-style pending bit mirrors the interrupt, but only when the revision-2 mode input is high at the time of the match.

Top module: `cmp_timer_unit`

## Requirements
- R1: While reset is held low, the counter and the comparison value read zero, all eight request lines are low, and the pending bit is low.
- R2: With `cnt_freeze` low and no counter write, the counter rises by exactly one on every tick edge (one tick per clock by default).
- R3: With `cnt_freeze` high, the counter holds its value and no match raises the interrupt. Once `cnt_freeze` drops, an equal counter and comparison value raises it at the next clock edge.
- R4: A write with `wr_sel`=0 loads `wr_data` into the counter at that clock edge. It takes priority over a tick in the same cycle, so the counter reads exactly `wr_data` afterwards. Counting then resumes from that value.
- R5: When the counter equals the comparison value while counting is enabled, the interrupt is raised at the following clock edge.
- R6: A write with `wr_sel`=1 stores `wr_data` as the comparison value and clears both the interrupt and the pending bit at that clock edge.
- R7: While the interrupt is active, exactly one request line is high, namely `irq_lines[route_sel]`. While it is inactive, all lines are low. A change of `route_sel` moves the active line at once.
- R8: Once raised, the interrupt stays active while the counter keeps advancing past the comparison value, until the next comparison write.
- R9: The pending bit is set by a match only when `rev2_mode` is high. With `rev2_mode` low, a match drives the request line but leaves the pending bit low.
- R10: The counter wraps from 0xFFFF_FFFF to 0, so a comparison value below the counter still matches after the rollover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_freeze | input | 1 | Disable-count control: 1 freezes the counter and blocks matches |
| rev2_mode | input | 1 | Enables the pending status bit |
| route_sel | input | 3 | Index of the request line that carries the interrupt |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter, 1 comparison value |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| compare_o | output | 32 | Current comparison value |
| irq_lines | output | 8 | One-hot interrupt request lines |
| timer_pending | output | 1 | Cause-style timer pending bit |

## Verification
A counter that skips or repeats a value shows up on `count_o` at the very next sample, and it also moves the match by one cycle, which the match tests pin to an exact cycle. A lost or stuck interrupt flag shows on `irq_lines` one edge after the match, or one edge after the comparison write. A wrong decode shows at once as a wrong bit or more than one bit. A pending bit that ignores the mode shows on the same edge as the interrupt.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int TMR_W   = 32;
  localparam int N_LINES = 8;
  localparam int ROUTE_W = $clog2(N_LINES);

  typedef enum logic {
    TGT_COUNT   = 1'b0,
    TGT_COMPARE = 1'b1
  } wr_target_e;

  // Next counter value: a write wins, then a tick while counting is enabled.
  function automatic logic [TMR_W-1:0] count_next(
    input logic [TMR_W-1:0] cur,
    input logic             load,
    input logic [TMR_W-1:0] load_val,
    input logic             tick,
    input logic             frozen
  );
    if (load)                 return load_val;
    else if (tick && !frozen) return cur + TMR_W'(1);
    else                      return cur;
  endfunction

  // One-hot line for a routing index, modulo the line count.
  function automatic logic [N_LINES-1:0] route_onehot(
    input logic               active,
    input logic [ROUTE_W-1:0] idx
  );
    logic [N_LINES-1:0] v;
    v = '0;
    if (active) v[idx] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/ctu_tick_gen.sv
module ctu_tick_gen #(
  parameter int TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                       phase_q <= phase_q + PH_W'(1);
  end

  assign tick_o = (phase_q == PH_LAST);

  assert_tick_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (TICK_DIV == 1) |-> tick_o);
endmodule

// File: rtl/ctu_counter.sv
module ctu_counter
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frozen,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic [TMR_W-1:0] count_o
);
  logic [TMR_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_next(count_q, load, load_val, tick, frozen);
  end

  assign count_o = count_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !load) |=> $stable(count_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !load && tick) |=> (count_q == $past(count_q) + TMR_W'(1)));
endmodule

// File: rtl/ctu_match_irq.sv
module ctu_match_irq
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] count,
  input  logic             frozen,
  input  logic             rev2,
  input  logic             cmp_wr,
  input  logic [TMR_W-1:0] cmp_val,
  output logic [TMR_W-1:0] compare_o,
  output logic             match_o,
  output logic             irq_o,
  output logic             pending_o
);
  logic [TMR_W-1:0] compare_q;
  logic             irq_q;
  logic             pend_q;

  assign match_o = (count == compare_q) && !frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      compare_q <= '0;
      irq_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else if (cmp_wr) begin
      compare_q <= cmp_val;
      irq_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else if (match_o) begin
      irq_q     <= 1'b1;
      if (rev2) pend_q <= 1'b1;
    end
  end

  assign compare_o = compare_q;
  assign irq_o     = irq_q;
  assign pending_o = pend_q;

  assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !cmp_wr) |=> irq_q);
  assert_cmp_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (!irq_q && !pend_q && compare_q == $past(cmp_val)));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !cmp_wr) |=> irq_q);
  assert_pend_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !rev2) |=> !pend_q);
  assert_pend_implies_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> irq_q);
endmodule

// File: rtl/ctu_router.sv
module ctu_router
  import cmp_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq,
  input  logic [ROUTE_W-1:0] route,
  output logic [N_LINES-1:0] lines
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign lines[i] = irq && (route == ROUTE_W'(i));
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($countones(lines) == 1 && lines == route_onehot(1'b1, route)));
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (lines == '0));
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import cmp_timer_pkg::*;
#(
  parameter int TICK_DIV = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_freeze,
  input  logic        rev2_mode,
  input  logic [2:0]  route_sel,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] count_o,
  output logic [31:0] compare_o,
  output logic [7:0]  irq_lines,
  output logic        timer_pending
);
  logic             tick;
  logic             cnt_wr;
  logic             cmp_wr;
  logic             match;
  logic             irq;
  logic [TMR_W-1:0] count;

  assign cnt_wr = wr_en && (wr_target_e'(wr_sel) == TGT_COUNT);
  assign cmp_wr = wr_en && (wr_target_e'(wr_sel) == TGT_COMPARE);

  ctu_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  ctu_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frozen(cnt_freeze),
    .load(cnt_wr), .load_val(wr_data), .count_o(count)
  );

  ctu_match_irq u_irq (
    .clk(clk), .rst_n(rst_n), .count(count), .frozen(cnt_freeze),
    .rev2(rev2_mode), .cmp_wr(cmp_wr), .cmp_val(wr_data),
    .compare_o(compare_o), .match_o(match), .irq_o(irq),
    .pending_o(timer_pending)
  );

  ctu_router u_route (
    .clk(clk), .rst_n(rst_n), .irq(irq), .route(route_sel), .lines(irq_lines)
  );

  assign count_o = count;

  assert_frozen_no_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_freeze && !irq) |=> !irq);
  assert_no_match_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !match) |=> !irq);
endmodule

// File: tb/cmp_timer_unit_tb.sv
module cmp_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_freeze = 1'b0;
  logic        rev2_mode = 1'b0;
  logic [2:0]  route_sel = 3'd0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o, compare_o;
  logic [7:0]  irq_lines;
  logic        timer_pending;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_freeze(cnt_freeze), .rev2_mode(rev2_mode),
    .route_sel(route_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .compare_o(compare_o), .irq_lines(irq_lines),
    .timer_pending(timer_pending)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] line_of(input logic [2:0] idx);
    return 8'(1) << idx;
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    check("R1 count", count_o, 32'd0);
    check("R1 compare", compare_o, 32'd0);
    check("R1 lines", {24'd0, irq_lines}, 32'd0);
    check("R1 pending", {31'd0, timer_pending}, 32'd0);
    rst_n = 1'b1;
    wr(1'b1, 32'h8000_0000);
    check("R6 compare stored", compare_o, 32'h8000_0000);
    check("R6 irq cleared", {24'd0, irq_lines}, 32'd0);
  endtask

  task automatic t_count;
    wr(1'b0, 32'd1000);
    check("R4 load exact", count_o, 32'd1000);
    wait_cyc(7);
    check("R2 advance", count_o, 32'd1007);
  endtask

  task automatic t_freeze;
    cnt_freeze = 1'b1;
    wr(1'b1, 32'd50);
    wr(1'b0, 32'd50);
    check("R3 load while frozen", count_o, 32'd50);
    wait_cyc(4);
    check("R3 held", count_o, 32'd50);
    check("R3 no irq frozen", {24'd0, irq_lines}, 32'd0);
    cnt_freeze = 1'b0;
    wait_cyc(1);
    check("R3 irq after unfreeze", {24'd0, irq_lines}, {24'd0, line_of(route_sel)});
    check("R2 resumes", count_o, 32'd51);
  endtask

  task automatic t_match;
    rev2_mode = 1'b1;
    route_sel = 3'd5;
    wr(1'b1, 32'd200);
    check("R6 clears irq", {24'd0, irq_lines}, 32'd0);
    wr(1'b0, 32'd195);
    wait_cyc(5);
    check("R5 count at compare", count_o, 32'd200);
    check("R5 no irq yet", {24'd0, irq_lines}, 32'd0);
    wait_cyc(1);
    check("R5 irq line", {24'd0, irq_lines}, 32'h20);
    check("R9 pending rev2", {31'd0, timer_pending}, 32'd1);
    wait_cyc(10);
    check("R8 sticky", {24'd0, irq_lines}, 32'h20);
    check("R8 count runs", count_o, 32'd211);
    route_sel = 3'd7;
    #1;
    check("R7 reroute", {24'd0, irq_lines}, 32'h80);
    route_sel = 3'd0;
    #1;
    check("R7 line0", {24'd0, irq_lines}, 32'h01);
    @(negedge clk);
    wr(1'b1, 32'h9000_0000);
    check("R6 ack irq", {24'd0, irq_lines}, 32'd0);
    check("R6 ack pending", {31'd0, timer_pending}, 32'd0);
  endtask

  task automatic t_no_rev2;
    rev2_mode = 1'b0;
    route_sel = 3'd2;
    wr(1'b1, 32'd400);
    wr(1'b0, 32'd398);
    wait_cyc(3);
    check("R9 line without rev2", {24'd0, irq_lines}, 32'h04);
    check("R9 no pending", {31'd0, timer_pending}, 32'd0);
    wr(1'b1, 32'h9000_0000);
  endtask

  task automatic t_wrap;
    rev2_mode = 1'b1;
    route_sel = 3'd3;
    wr(1'b1, 32'd3);
    wr(1'b0, 32'hFFFF_FFFE);
    wait_cyc(2);
    check("R10 rollover", count_o, 32'd0);
    wait_cyc(3);
    check("R10 at compare", count_o, 32'd3);
    check("R10 no irq yet", {24'd0, irq_lines}, 32'd0);
    wait_cyc(1);
    check("R10 irq after wrap", {24'd0, irq_lines}, 32'h08);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_count;
    t_freeze;
    t_match;
    t_no_rev2;
    t_wrap;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule